// File: doc/BRIEF.md
# Supply-Good Access Inhibit Sequencer

This block sits on the control path between a memory controller and an external non-volatile memory. It keeps the memory's active-low chip enable and write enable strobes forced high whenever the supply cannot be trusted. Two digital flags come from supply monitors. The first, supply-good, says the supply is above its operating minimum. The second, write-inhibit, says the supply has fallen below the level at which writes are safe. Both flags arrive asynchronously. The block synchronizes them and filters supply-good before acting on it.

After the supply becomes good and write-inhibit clears, the block waits through a fixed warm-up time. Only then does it pass the controller's strobes through and raise `ready`. The warm-up length is derived from a clock frequency, a delay in microseconds and a percentage margin. The defaults give 2 ms plus 1 % at 100 MHz, which is 202000 cycles. A brownout at any time drops the block back to the blocked state. Every recovery then repeats the full warm-up. When a brownout cuts off an access in progress, the block pulses `abort` for one cycle so the controller knows that access did not complete.

Top module: `supply_access_guard`

## Requirements
- R1: While `rst_n` is low and right after reset, `ready` is 0, `abort` is 0, and both `mem_ce_n` and `mem_we_n` are 1.
- R2: Whenever `ready` is 0, `mem_ce_n` and `mem_we_n` are both 1, whatever levels `req_ce_n` and `req_we_n` have.
- R3: Whenever `ready` is 1, `mem_ce_n` equals `req_ce_n` and `mem_we_n` equals `req_we_n` in the same cycle, with no register in between.
- R4: From the blocked state, with write-inhibit low, `ready` first reads 1 at the falling clock edge STABLE_CYC+WAIT+3 edges after `supply_ok_raw` is raised. Here WAIT is the warm-up length in cycles, and the count starts at the first falling edge after the flag changes.
- R5: The warm-up length is WAIT = ceil(B*(100+MARGIN_PCT)/100), where B = ceil(CLK_HZ*WAIT_US/1000000). For the defaults this is 202000 cycles.
- R6: A high run of the synchronized supply-good flag shorter than STABLE_CYC cycles is ignored: `ready` stays 0. A later high run that lasts long enough still obeys R4 in full.
- R7: While `wr_inhibit_raw` is 1, `ready` stays 0 even with supply-good high. When write-inhibit falls with supply-good already filtered high, `ready` first reads 1 at the falling edge WAIT+3 edges later.
- R8: From the ready state, raising `wr_inhibit_raw` makes `ready` read 0, with both strobes 1, at the third falling edge. Lowering `supply_ok_raw` does the same at the fourth falling edge.
- R9: A brownout during the warm-up discards the progress made so far. After the flag clears, the full WAIT+3 latency of R7 applies again.
- R10: `abort` is a single-cycle pulse. It goes high in the first cycle after `ready` falls, and only if `req_ce_n` was 0 when the brownout was taken. No pulse follows a brownout while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok_raw | input | 1 | Asynchronous flag: supply above its operating minimum |
| wr_inhibit_raw | input | 1 | Asynchronous flag: supply below the write-safe threshold |
| req_ce_n | input | 1 | Chip enable request from the controller, active low |
| req_we_n | input | 1 | Write enable request from the controller, active low |
| mem_ce_n | output | 1 | Chip enable to the memory, active low, forced high while blocked |
| mem_we_n | output | 1 | Write enable to the memory, active low, forced high while blocked |
| ready | output | 1 | High when accesses are allowed through |
| abort | output | 1 | One-cycle pulse when a brownout cut off an active access |

## Verification
Any fault in the sequencer state shows up at the ports as soon as it matters. If the state sits in the run state too early, the strobes follow the requests while `ready` should be low. This is seen within one cycle of the first active request. A warm-up counter that fails to clear or to restart moves the `ready` rise off its exact edge. The bench therefore measures that edge to the cycle after a cold start, after a write-inhibit release, after a filtered glitch and after a mid-warm-up brownout. A wrong exit path moves the `ready` fall or the `abort` pulse by at least one edge, or adds or drops the pulse. The bench samples both signals on every cycle around a brownout.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [1:0] {
    GS_HOLD   = 2'd0,
    GS_WARMUP = 2'd1,
    GS_RUN    = 2'd2
  } guard_state_t;

  // Warm-up cycles: delay rounded up to whole cycles, then margin added, rounded up.
  function automatic longint warmup_cycles(longint clk_hz, longint delay_us,
                                           longint margin_pct);
    longint base;
    base = (clk_hz * delay_us + 64'd999_999) / 64'd1_000_000;
    return (base * (64'd100 + margin_pct) + 64'd99) / 64'd100;
  endfunction

  // Counter width able to hold values 0..n.
  function automatic int count_width(longint n);
    int w;
    w = 1;
    while ((64'd1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sg_sync2.sv
module sg_sync2 #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta  <= RST_VAL[i];
        stage <= RST_VAL[i];
      end else begin
        meta  <= d_async[i];
        stage <= meta;
      end
    end
    assign q_sync[i] = stage;
  end
endmodule

// File: rtl/sg_stable_filter.sv
module sg_stable_filter
  import supply_guard_pkg::*;
#(
  parameter int STABLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = count_width(longint'(STABLE_CYC));

  logic [CW-1:0] run_len;
  logic          run_full;

  assign run_full = (run_len == CW'(STABLE_CYC));

  // Rise only after STABLE_CYC consecutive high samples; fall on the first low one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      dout    <= 1'b0;
    end else if (!din) begin
      run_len <= '0;
      dout    <= 1'b0;
    end else begin
      if (!run_full) run_len <= run_len + 1'b1;
      if (run_len >= CW'(STABLE_CYC - 1)) dout <= 1'b1;
    end
  end
endmodule

// File: rtl/sg_warmup_timer.sv
module sg_warmup_timer
  import supply_guard_pkg::*;
#(
  parameter int WAIT_CYC = 202000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = count_width(longint'(WAIT_CYC));

  logic [CW-1:0] elapsed;

  assign done = run && (elapsed == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elapsed <= '0;
    else if (!run)    elapsed <= '0;
    else if (!done)   elapsed <= elapsed + 1'b1;
  end
endmodule

// File: rtl/supply_access_guard.sv
module supply_access_guard
  import supply_guard_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter longint WAIT_US    = 2000,
  parameter longint MARGIN_PCT = 1,
  parameter int     STABLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_raw,
  input  logic wr_inhibit_raw,
  input  logic req_ce_n,
  input  logic req_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic ready,
  output logic abort
);
  localparam int WAIT_CYC = int'(warmup_cycles(CLK_HZ, WAIT_US, MARGIN_PCT));

  // Named internal events, used by the bound checker.
  logic         ok_sync, inh_sync, ok_stable, brownout;
  logic         in_warmup, warmup_done, in_run;
  logic [1:0]   flags_sync;
  guard_state_t state, state_nxt;

  // Write-inhibit resets to 1 so the path starts out blocked.
  sg_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({wr_inhibit_raw, supply_ok_raw}),
    .q_sync  (flags_sync)
  );
  assign ok_sync  = flags_sync[0];
  assign inh_sync = flags_sync[1];

  sg_stable_filter #(.STABLE_CYC(STABLE_CYC)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ok_sync),
    .dout  (ok_stable)
  );

  assign brownout  = !ok_stable || inh_sync;
  assign in_warmup = (state == GS_WARMUP);
  assign in_run    = (state == GS_RUN);

  sg_warmup_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_warmup),
    .done  (warmup_done)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      GS_HOLD:   if (!brownout) state_nxt = GS_WARMUP;
      GS_WARMUP: if (brownout) state_nxt = GS_HOLD;
                 else if (warmup_done) state_nxt = GS_RUN;
      GS_RUN:    if (brownout) state_nxt = GS_HOLD;
      default:   state_nxt = GS_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GS_HOLD;
      abort <= 1'b0;
    end else begin
      state <= state_nxt;
      abort <= in_run && brownout && !req_ce_n;
    end
  end

  assign ready    = in_run;
  assign mem_ce_n = req_ce_n | ~in_run;
  assign mem_we_n = req_we_n | ~in_run;

endmodule

// File: rtl/sg_guard_checker.sv
module sg_guard_checker
  import supply_guard_pkg::*;
#(
  parameter int WAIT_CYC   = 4,
  parameter int STABLE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ok_sync,
  input logic inh_sync,
  input logic ok_stable,
  input logic in_warmup,
  input logic ready,
  input logic abort,
  input logic mem_ce_n,
  input logic mem_we_n
);
  localparam int WW = count_width(longint'(WAIT_CYC) + 1);
  localparam int SW = count_width(longint'(STABLE_CYC) + 1);

  logic [WW-1:0] warm_len;
  logic [SW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_len <= '0;
      hi_len   <= '0;
    end else begin
      if (!in_warmup) warm_len <= '0;
      else if (warm_len != WW'(WAIT_CYC + 1)) warm_len <= warm_len + 1'b1;
      if (!ok_sync) hi_len <= '0;
      else if (hi_len != SW'(STABLE_CYC)) hi_len <= hi_len + 1'b1;
    end
  end

  AST_STROBES_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (mem_ce_n && mem_we_n)); // R2
  AST_FULL_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (warm_len == WW'(WAIT_CYC))); // R4
  AST_FILTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_stable) |-> (hi_len >= SW'(STABLE_CYC))); // R6
  AST_INHIBIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    inh_sync |=> !ready); // R8
  AST_SUPPLY_LOSS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_stable |=> !ready); // R8
  AST_ABORT_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!ready && $past(ready))); // R10
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort); // R10
endmodule

bind supply_access_guard sg_guard_checker #(
  .WAIT_CYC   (WAIT_CYC),
  .STABLE_CYC (STABLE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ok_sync   (ok_sync),
  .inh_sync  (inh_sync),
  .ok_stable (ok_stable),
  .in_warmup (in_warmup),
  .ready     (ready),
  .abort     (abort),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n)
);

// File: tb/sim_supply_access_guard.sv
`timescale 1ns/1ps
module sim_supply_access_guard;
  localparam longint T_HZ  = 1_000_000;
  localparam longint T_US  = 50;
  localparam longint T_MRG = 10;
  localparam int     T_STB = 4;
  // 1 MHz gives one cycle per microsecond: 50 cycles, plus 10 % rounded up = 55.
  localparam int EXP_W = (int'(T_US) * (100 + int'(T_MRG)) + 99) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ok_raw = 1'b0, inh_raw = 1'b1, rq_ce = 1'b0, rq_we = 1'b0;
  logic m_ce, m_we, rdy, abt;
  int   total = 0, bad = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  supply_access_guard #(
    .CLK_HZ(T_HZ), .WAIT_US(T_US), .MARGIN_PCT(T_MRG), .STABLE_CYC(T_STB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(ok_raw), .wr_inhibit_raw(inh_raw),
    .req_ce_n(rq_ce), .req_we_n(rq_we), .mem_ce_n(m_ce), .mem_we_n(m_we),
    .ready(rdy), .abort(abt)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic latency(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rdy && n < 1000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", rdy, 0);
    chk("R1", "abort in reset", abt, 0);
    chk("R1", "strobes in reset", {m_ce, m_we}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "strobes blocked after reset with requests low", {m_ce, m_we}, 2'b11);
  endtask

  task automatic t_hold_inhibit();
    int seen = 0;
    ok_raw = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rdy || !m_ce || !m_we) seen++;
    end
    chk("R7", "cycles unblocked while write-inhibit high", seen, 0);
  endtask

  task automatic t_release_inhibit();
    int n;
    inh_raw = 1'b0;
    latency(n);
    chk("R7", "ready latency after inhibit release (R5 length)", n, EXP_W + 3);
  endtask

  task automatic t_passthrough();
    for (int p = 0; p < 4; p++) begin
      rq_ce = p[1];
      rq_we = p[0];
      #2;
      chk("R3", "mem_ce_n follows request", m_ce, p[1]);
      chk("R3", "mem_we_n follows request", m_we, p[0]);
      @(negedge clk);
    end
  endtask

  task automatic t_brownout_active();
    int n;
    rq_ce = 1'b0;
    rq_we = 1'b0;
    @(negedge clk);
    inh_raw = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i < 3) begin
        chk("R8", "ready before inhibit takes effect", rdy, 1);
        chk("R10", "no early abort", abt, 0);
      end else if (i == 3) begin
        chk("R8", "ready dropped on third edge", rdy, 0);
        chk("R8", "strobes forced on third edge", {m_ce, m_we}, 2'b11);
        chk("R10", "abort pulse on active access", abt, 1);
      end else begin
        chk("R10", "abort lasts one cycle", abt, 0);
      end
    end
    rq_ce = 1'b1;
    rq_we = 1'b1;
    inh_raw = 1'b0;
    latency(n);
    chk("R7", "recovery latency after brownout", n, EXP_W + 3);
  endtask

  task automatic t_supply_loss_idle();
    int ab = 0;
    @(negedge clk);
    ok_raw = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (abt) ab++;
      if (i == 3) chk("R8", "ready still high at third edge", rdy, 1);
      if (i == 4) chk("R8", "ready dropped at fourth edge on supply loss", rdy, 0);
    end
    chk("R10", "abort pulses while idle", ab, 0);
  endtask

  task automatic t_glitch();
    int n, seen = 0;
    ok_raw = 1'b1;
    repeat (T_STB - 1) @(negedge clk);
    ok_raw = 1'b0;
    for (int i = 0; i < 20 + EXP_W; i++) begin
      @(negedge clk);
      if (rdy) seen++;
    end
    chk("R6", "ready after short supply-good glitch", seen, 0);
    ok_raw = 1'b1;
    latency(n);
    chk("R4", "cold start latency after glitch (R6, R5)", n, T_STB + EXP_W + 3);
  endtask

  task automatic t_restart_midwait();
    int n;
    inh_raw = 1'b1;
    repeat (5) @(negedge clk);
    inh_raw = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9", "ready low in mid warm-up", rdy, 0);
    inh_raw = 1'b1;
    repeat (5) @(negedge clk);
    inh_raw = 1'b0;
    latency(n);
    chk("R9", "full latency after mid warm-up brownout", n, EXP_W + 3);
  endtask

  initial begin
    #(10ns * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold_inhibit();
    t_release_inhibit();
    t_passthrough();
    t_brownout_active();
    t_supply_loss_idle();
    t_glitch();
    t_restart_midwait();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule